// File: doc/BRIEF.md
# Reverse Link Table Clear Generator

This block fills a region of RAM with an empty, backward-linked list. It moves no payload. After one start request it writes a descending run of 32-bit words, one per clock. Each word holds the 24-bit address of the word four bytes below it. The lowest word written holds the all-ones 24-bit end marker `0x00FFFFFF`. A list walker that later starts at the top entry therefore steps downward through every entry and stops at the marker.

The block accepts a request only when two conditions hold. The channel control word must carry this mode's exact encoding, and the channel's enable bit from the priority/enable register must be set. Software sees the transfer as finished only after a fixed latency, counted from the accepting edge. The writes themselves finish long before that in the usual case. Requests that arrive while a transfer is in flight are dropped.

Top module: `list_clear_gen`

## Requirements
- R1: A request is accepted only on a rising edge where `start_i` is high, the block is idle, `ctrl_i` equals `32'h1100_0002` (bit 24 is the start flag and is part of that word), and `chan_en_i` is high. Otherwise the request is ignored: no write, no `busy_o` and no `done_o`.
- R2: The first write goes to `base_i` masked with 2^RAM_AW-1. With the default RAM_AW=21 the mask is `0x1FFFFF`.
- R3: A link entry written at address A carries `{8'h00, (A-4) mod 2^24}`. The next write goes to (A-4) mod 2^24 in the very next cycle. Writes start in the cycle after the accepting edge.
- R4: For a count N>0, exactly N words are written. The first N-1 are link entries and the last is `32'h00FF_FFFF` at the lowest address.
- R5: A count of zero writes nothing, but the transfer still completes.
- R6: For N <= DELAY (default 2150), `done_o` is high for exactly one cycle. That cycle follows the DELAY-th rising edge after the accepting edge, and `busy_o` falls at the same edge.
- R7: For N > DELAY, `done_o` pulses in the cycle after the N-th rising edge after acceptance, which is right after the terminator write.
- R8: A `start_i` pulse while `busy_o` is high changes neither the write sequence nor the completion time.
- R9: `ram_we_o` is low whenever the block is idle, from reset and between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| ctrl_i | input | 32 | Channel control word |
| chan_en_i | input | 1 | This channel's enable bit from the priority/enable register |
| base_i | input | 24 | Start (highest) address |
| count_i | input | 32 | Number of entries |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 24 | RAM byte address |
| ram_wdata_o | output | 32 | RAM write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the point where the address walk goes through zero and wraps to the top of the 24-bit space. The other hard situation is a count longer than the completion latency, where the last write, rather than the timer, decides when completion fires. Directed runs reach both cases. One starts four bytes above zero so that the walk wraps. Another uses a count of 2200, which is larger than the 2150-cycle latency. A further run pulses `start_i` in the middle of a transfer with a different base, to show that it is dropped.

// File: rtl/list_clear_gen.sv
module list_clear_gen #(
  parameter int          RAM_AW    = 21,
  parameter int          DELAY     = 2150,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] MODE_WORD = 32'h1100_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       ctrl_i,
  input  logic              chan_en_i,
  input  logic [23:0]       base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ram_we_o,
  output logic [23:0]       ram_addr_o,
  output logic [31:0]       ram_wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int          TW    = $clog2(DELAY + 1);
  localparam logic [23:0] AMASK = 24'((64'd1 << RAM_AW) - 64'd1);
  localparam logic [31:0] TERM  = 32'h00FF_FFFF;

  logic             busy, done;
  logic [23:0]      addr;
  logic [CNT_W-1:0] rem;
  logic [TW-1:0]    tmr;

  wire go     = start_i && !busy && chan_en_i && (ctrl_i == MODE_WORD);
  wire last   = rem <= CNT_W'(1);
  wire tmr_up = tmr == TW'(DELAY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      addr <= '0;
      rem  <= '0;
      tmr  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        addr <= base_i & AMASK;
        rem  <= count_i;
        tmr  <= '0;
      end else if (busy) begin
        if (rem != '0) begin
          addr <= addr - 24'd4;
          rem  <= rem - CNT_W'(1);
        end
        if (!tmr_up) tmr <= tmr + TW'(1);
        if (tmr_up && last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign ram_we_o    = busy && (rem != '0);
  assign ram_addr_o  = addr;
  assign ram_wdata_o = last ? TERM : {8'h00, addr - 24'd4};
  assign busy_o      = busy;
  assign done_o      = done;

  // R3
  descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o && $past(ram_we_o) |-> ram_addr_o == $past(ram_addr_o) - 24'd4);

  // R3
  link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ram_we_o) && $past(ram_wdata_o) != TERM && ram_we_o
      |-> ram_addr_o == $past(ram_wdata_o[23:0]));

  // R4
  term_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o && ram_wdata_o == TERM |=> !ram_we_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !ram_we_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ram_we_o);
endmodule

// File: tb/test_list_clear_gen.sv
`timescale 1ns/1ps
module test_list_clear_gen;
  localparam int          DELAY = 2150;
  localparam logic [23:0] MASK  = 24'h1F_FFFF;
  localparam logic [31:0] MODE  = 32'h1100_0002;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, en = 1'b0;
  logic [31:0] ctrl = '0, cnt = '0;
  logic [23:0] base = '0;
  logic        we, busy, done;
  logic [23:0] waddr;
  logic [31:0] wdata;

  int checks = 0, errors = 0;
  logic [23:0] wa [0:4095];
  logic [31:0] wd [0:4095];

  always #5 clk = ~clk;

  list_clear_gen i_list_clear_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_i(ctrl), .chan_en_i(en),
    .base_i(base), .count_i(cnt), .ram_we_o(we), .ram_addr_o(waddr),
    .ram_wdata_o(wdata), .busy_o(busy), .done_o(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string req, input logic [23:0] b, input logic [31:0] n,
                          input logic [31:0] c, input logic e, input bit accept,
                          input bit mid_start);
    int nw = 0, ndone = 0, done_at = 0, lim;
    int bad = -1;
    logic [23:0] a;
    logic [31:0] d;
    lim = ((n > DELAY) ? int'(n) : DELAY) + 20;
    @(negedge clk);
    base = b; cnt = n; ctrl = c; en = e; start = 1'b1;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 1) chk(busy == accept, req, "busy after request", busy, accept);
      if (mid_start && k == 3) begin
        base = 24'h00_8000; cnt = 32'd7; start = 1'b1;
      end
      if (we) begin
        if (nw < 4096) begin wa[nw] = waddr; wd[nw] = wdata; end
        nw++;
      end
      if (done) begin
        ndone++;
        if (done_at == 0) done_at = k;
      end
    end
    start = 1'b0;
    chk(nw == (accept ? int'(n) : 0), req, "write count", nw, accept ? n : 0);
    a = b & MASK;
    if (accept) begin
      for (int i = 0; i < int'(n) && i < 4096; i++) begin
        d = (i == int'(n) - 1) ? 32'h00FF_FFFF : {8'h00, a - 24'd4};
        if (bad < 0 && (wa[i] != a || wd[i] != d)) bad = i;
        a = a - 24'd4;
      end
      chk(bad < 0, req, "entry address/data mismatch index", bad, -1);
      chk(ndone == 1, req, "done pulse count", ndone, 1);
      chk(done_at == ((n > DELAY) ? int'(n) : DELAY) + 1, "R6/R7", "done cycle",
          done_at, ((n > DELAY) ? n : DELAY) + 1);
    end else begin
      chk(ndone == 0, req, "done pulses when rejected", ndone, 0);
    end
    chk(!busy && !we, "R9", "idle after case", {busy, we}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!we && !busy && !done, "R9", "reset state", {we, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!we && !busy && !done, "R9", "idle after reset", {we, busy, done}, 0);
    // R3 R4 R6: basic run of five entries
    run_case("R3", 24'h00_1000, 32'd5, MODE, 1'b1, 1'b1, 1'b0);
    // R4: single entry gets only the terminator
    run_case("R4", 24'h00_2000, 32'd1, MODE, 1'b1, 1'b1, 1'b0);
    // R5: zero count
    run_case("R5", 24'h00_3000, 32'd0, MODE, 1'b1, 1'b1, 1'b0);
    // R2: base masked to RAM size
    run_case("R2", 24'hFF_F010, 32'd2, MODE, 1'b1, 1'b1, 1'b0);
    // R3: walk wraps through zero
    run_case("R3", 24'h00_0004, 32'd3, MODE, 1'b1, 1'b1, 1'b0);
    // R1: start flag bit 24 clear, enable clear, wrong mode word
    run_case("R1", 24'h00_1000, 32'd4, MODE & ~32'h0100_0000, 1'b1, 1'b0, 1'b0);
    run_case("R1", 24'h00_1000, 32'd4, MODE, 1'b0, 1'b0, 1'b0);
    run_case("R1", 24'h00_1000, 32'd4, 32'h0100_0200, 1'b1, 1'b0, 1'b0);
    // R8: start while busy ignored
    run_case("R8", 24'h00_4000, 32'd6, MODE, 1'b1, 1'b1, 1'b1);
    // R7: count longer than delay
    run_case("R7", 24'h01_0000, 32'd2200, MODE, 1'b1, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule